// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block runs one multichannel conversion scan each time a command arrives on its register-side command port. The command carries a bitmask of the input channels wanted, a flag that asks for a temperature reading, and an averaging code. The controller then raises the converter's power enable and waits a fixed wake-up time. If a temperature reading was asked for, it takes that reading first. It then steps the input multiplexer select through the set channels, lowest index first. On each channel it runs the number of conversions the averaging code selects and writes one averaged result into a result FIFO. When the last channel is done, it drops the power enable and pulls the active-low end-of-conversion flag low.

The converter sits outside the block. It is reached through a one-cycle start strobe, a one-cycle done strobe and a 12-bit result. FIFO entries are 16 bits: a 4-bit tag above the 12-bit result. The tag holds the channel index, or 0xF for the temperature entry. The end-of-conversion flag stays low until chip select is next seen low, so a host can poll it between register accesses. While a scan runs, the block takes no notice of further commands. Software reads the FIFO through a show-ahead read port.

Top module: `adcScanSeq`

## Requirements
- R1: After reset, eocN is 1, adcPowerUp is 0, fifoEmpty is 1 and fifoOverflow is 0.
- R2: A command (cmdValid high while idle) starts a scan with no other trigger. adcPowerUp is high whenever adcStart is high. The first adcStart comes no sooner than WAKE_CYCLES cycles after the command.
- R3: When cmdTempReq is set, exactly one conversion is made with adcTempSel high. Its result is the first FIFO entry of the scan, with tag 0xF in bits [15:12] and the raw 12-bit result in bits [11:0]. It is never averaged.
- R4: Channels whose bit is set in cmdChanMask are converted in ascending index order. muxSel equals the channel index during each of that channel's conversions. Each channel entry carries its index in bits [15:12].
- R5: The averaging code in cmdAvgSel selects conversions per channel entry: 0→1, 1→4, 2→8, 3→16, 4→32, and codes 5 to 7 act as 1. The entry value is the sum of those conversions shifted right by log2 of the count. Exactly that many adcStart pulses are issued per channel.
- R6: When a scan ends, eocN goes low and stays low for as long as csN stays high. The first cycle csN is sampled low sets eocN high again.
- R7: adcPowerUp is 0 from the cycle eocN falls until the next command.
- R8: A command with a zero mask and no temperature request issues no adcStart, writes nothing to the FIFO, and pulls eocN low.
- R9: A write to a full FIFO (depth FIFO_DEPTH) is dropped and sets fifoOverflow. fifoOverflow stays set until reset. The entries already stored are kept.
- R10: A command that arrives while a scan is active has no effect on that scan or on the FIFO contents.
- R11: fifoRdData shows the oldest entry while fifoEmpty is 0. A cycle with fifoRdEn high removes that entry. A read while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle command write strobe |
| cmdChanMask | input | 16 | Channels to scan, bit n selects channel n |
| cmdTempReq | input | 1 | Request a temperature conversion first |
| cmdAvgSel | input | 3 | Averaging code |
| csN | input | 1 | Active-low chip select; clears the end flag |
| adcDone | input | 1 | Converter result valid strobe |
| adcData | input | 12 | Converter result |
| adcPowerUp | output | 1 | Converter power enable |
| adcStart | output | 1 | Converter start strobe |
| adcTempSel | output | 1 | Route the temperature sensor to the converter |
| muxSel | output | 4 | Input multiplexer channel select |
| eocN | output | 1 | Active-low end-of-scan flag |
| fifoRdEn | input | 1 | Pop the oldest FIFO entry |
| fifoRdData | output | 16 | Oldest FIFO entry (tag and result) |
| fifoEmpty | output | 1 | FIFO holds no entries |
| fifoOverflow | output | 1 | Sticky: a result was dropped on a full FIFO |

## Verification
The converter model returns values that depend on the mux select and on the conversion's position in the scan. A sequencer that skips a channel, repeats one, takes channels in the wrong order, or averages over the wrong count therefore produces wrong tagged values, and the adcStart totals also come out wrong. The bench waits several cycles after the scan ends before raising chip select, so a flag that releases on its own, or a power enable left on, is caught. The bench also covers the edge cases: an empty command that must finish without converting, a second command fired in the middle of a long averaged scan, which must not widen the scan, and two back-to-back full scans that must overflow the FIFO. In the overflow case the stored entries must be exactly the first FIFO_DEPTH written, which catches a FIFO that overwrites old data or wraps.

// File: rtl/adcScanPkg.sv
package adcScanPkg;
  localparam int DATA_W   = 12;
  localparam int TAG_W    = 4;
  localparam int ENTRY_W  = TAG_W + DATA_W;
  localparam int MAX_SHIFT = 5;
  localparam logic [TAG_W-1:0] TEMP_TAG = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_PICK, ST_START, ST_WAIT, ST_WRITE, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic             accClear;
    logic             accAdd;
    logic             push;
    logic [TAG_W-1:0] tag;
    logic [2:0]       shift;
  } seqStrobes_t;

  function automatic logic [2:0] avgShiftOf(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd4;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/adcScanCtrl.sv
module adcScanCtrl
  import adcScanPkg::*;
#(
  parameter int CHANS       = 16,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CHANS-1:0]  cmdChanMask,
  input  logic              cmdTempReq,
  input  logic [2:0]        cmdAvgSel,
  input  logic              csN,
  input  logic              adcDone,
  output logic              adcPowerUp,
  output logic              adcStart,
  output logic              adcTempSel,
  output logic [TAG_W-1:0]  muxSel,
  output logic              eocN,
  output seqStrobes_t       strb
);
  localparam int CHAN_W = (CHANS > 1) ? $clog2(CHANS) : 1;
  localparam int WAKE_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) + 1 : 1;

  seqState_t          state;
  logic [CHANS-1:0]   remMask;
  logic               tempPending;
  logic [2:0]         avgShift;
  logic [2:0]         curShift;
  logic [TAG_W-1:0]   curTag;
  logic [CHAN_W-1:0]  curChan;
  logic [5:0]         sampleCnt;
  logic [WAKE_W-1:0]  wakeCnt;
  logic               tempSelReg;
  logic [TAG_W-1:0]   muxReg;
  logic               eocReg;

  // lowest set channel among those still pending
  logic               chanFound;
  logic [CHAN_W-1:0]  chanIdx;
  always_comb begin
    chanFound = 1'b0;
    chanIdx   = '0;
    for (int i = CHANS - 1; i >= 0; i--) begin
      if (remMask[i]) begin
        chanFound = 1'b1;
        chanIdx   = CHAN_W'(i);
      end
    end
  end

  logic lastSample;
  assign lastSample = (sampleCnt == ((6'd1 << curShift) - 6'd1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      remMask     <= '0;
      tempPending <= 1'b0;
      avgShift    <= '0;
      curShift    <= '0;
      curTag      <= '0;
      curChan     <= '0;
      sampleCnt   <= '0;
      wakeCnt     <= '0;
      tempSelReg  <= 1'b0;
      muxReg      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            remMask     <= cmdChanMask;
            tempPending <= cmdTempReq;
            avgShift    <= avgShiftOf(cmdAvgSel);
            wakeCnt     <= '0;
            state       <= (cmdChanMask == '0 && !cmdTempReq) ? ST_DONE : ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (wakeCnt == WAKE_W'(WAKE_CYCLES - 1)) state <= ST_PICK;
          else wakeCnt <= wakeCnt + 1'b1;
        end
        ST_PICK: begin
          sampleCnt <= '0;
          if (tempPending) begin
            curTag     <= TEMP_TAG;
            curShift   <= '0;
            tempSelReg <= 1'b1;
            state      <= ST_START;
          end else if (chanFound) begin
            curTag     <= TAG_W'(chanIdx);
            curChan    <= chanIdx;
            muxReg     <= TAG_W'(chanIdx);
            curShift   <= avgShift;
            tempSelReg <= 1'b0;
            state      <= ST_START;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: begin
          if (adcDone) begin
            if (lastSample) state <= ST_WRITE;
            else begin
              sampleCnt <= sampleCnt + 6'd1;
              state     <= ST_START;
            end
          end
        end
        ST_WRITE: begin
          if (tempSelReg) tempPending <= 1'b0;
          else remMask[curChan] <= 1'b0;
          tempSelReg <= 1'b0;
          state      <= ST_PICK;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eocReg <= 1'b1;
    else if (state == ST_DONE) eocReg <= 1'b0;
    else if (!csN) eocReg <= 1'b1;
  end

  always_comb begin
    strb.accClear = (state == ST_PICK);
    strb.accAdd   = (state == ST_WAIT) && adcDone;
    strb.push     = (state == ST_WRITE);
    strb.tag      = curTag;
    strb.shift    = curShift;
  end

  assign adcStart   = (state == ST_START);
  assign adcPowerUp = (state != ST_IDLE) && (state != ST_DONE);
  assign adcTempSel = tempSelReg;
  assign muxSel     = muxReg;
  assign eocN       = eocReg;

  // R2
  start_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> adcPowerUp);
  // R6
  eoc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eocN && csN) |=> !eocN);
  // R7
  power_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> !adcPowerUp);
  // R3
  temp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcTempSel && strb.accAdd) |=> strb.push);
endmodule

// File: rtl/adcScanData.sv
module adcScanData
  import adcScanPkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [DATA_W-1:0]  adcData,
  input  logic               fifoRdEn,
  output logic [ENTRY_W-1:0] fifoRdData,
  output logic               fifoEmpty,
  output logic               fifoOverflow
);
  localparam int ACC_W = DATA_W + MAX_SHIFT;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [ACC_W-1:0]   acc;
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               full, doWrite, doRead;
  logic [ACC_W-1:0]   avgWide;
  logic [ENTRY_W-1:0] pushWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strb.accClear) acc <= '0;
    else if (strb.accAdd) acc <= acc + ACC_W'(adcData);
  end

  assign avgWide  = acc >> strb.shift;
  assign pushWord = {strb.tag, avgWide[DATA_W-1:0]};

  assign full    = (count == CNT_W'(FIFO_DEPTH));
  assign doWrite = strb.push && !full;
  assign doRead  = fifoRdEn && (count != '0);

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      count        <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRead)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doWrite) - CNT_W'(doRead);
      if (strb.push && full) fifoOverflow <= 1'b1;
    end
  end

  assign fifoRdData = mem[rdPtr];
  assign fifoEmpty  = (count == '0);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full && !fifoRdEn) |=> (count == CNT_W'(FIFO_DEPTH)));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);
  // R11
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && fifoRdEn && !strb.push) |=> fifoEmpty);
endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import adcScanPkg::*;
#(
  parameter int CHANS       = 16,
  parameter int WAKE_CYCLES = 4,
  parameter int FIFO_DEPTH  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [CHANS-1:0]   cmdChanMask,
  input  logic               cmdTempReq,
  input  logic [2:0]         cmdAvgSel,
  input  logic               csN,
  input  logic               adcDone,
  input  logic [DATA_W-1:0]  adcData,
  output logic               adcPowerUp,
  output logic               adcStart,
  output logic               adcTempSel,
  output logic [TAG_W-1:0]   muxSel,
  output logic               eocN,
  input  logic               fifoRdEn,
  output logic [ENTRY_W-1:0] fifoRdData,
  output logic               fifoEmpty,
  output logic               fifoOverflow
);
  seqStrobes_t strb;

  adcScanCtrl #(.CHANS(CHANS), .WAKE_CYCLES(WAKE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChanMask(cmdChanMask),
    .cmdTempReq(cmdTempReq), .cmdAvgSel(cmdAvgSel), .csN(csN), .adcDone(adcDone),
    .adcPowerUp(adcPowerUp), .adcStart(adcStart), .adcTempSel(adcTempSel),
    .muxSel(muxSel), .eocN(eocN), .strb(strb)
  );

  adcScanData #(.FIFO_DEPTH(FIFO_DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .adcData(adcData), .fifoRdEn(fifoRdEn),
    .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty), .fifoOverflow(fifoOverflow)
  );
endmodule

// File: tb/adcScanSeq_tb.sv
module adcScanSeq_tb_top;
  localparam int WAKE = 4;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdChanMask = '0;
  logic cmdTempReq = 1'b0;
  logic [2:0] cmdAvgSel = '0;
  logic csN = 1'b1;
  logic adcDone = 1'b0;
  logic [11:0] adcData = '0;
  logic fifoRdEn = 1'b0;
  logic adcPowerUp, adcStart, adcTempSel, eocN, fifoEmpty, fifoOverflow;
  logic [3:0] muxSel;
  logic [15:0] fifoRdData;

  adcScanSeq #(.CHANS(16), .WAKE_CYCLES(WAKE), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChanMask(cmdChanMask),
    .cmdTempReq(cmdTempReq), .cmdAvgSel(cmdAvgSel), .csN(csN), .adcDone(adcDone),
    .adcData(adcData), .adcPowerUp(adcPowerUp), .adcStart(adcStart),
    .adcTempSel(adcTempSel), .muxSel(muxSel), .eocN(eocN), .fifoRdEn(fifoRdEn),
    .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty), .fifoOverflow(fifoOverflow)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  int startCount = 0;
  int baseStart = 0;
  int cmdCycle = 0;
  int firstStartCyc = 0;
  int powerViol = 0;
  int pendCnt = 0;
  logic [11:0] pendVal = '0;

  function automatic logic [11:0] chanVal(input int ch, input int idx);
    return 12'(ch * 240 + 10 + (idx % 5) * 3);
  endfunction
  function automatic logic [11:0] tempVal(input int idx);
    return 12'(2700 + idx);
  endfunction

  always @(negedge clk) begin
    adcDone <= 1'b0;
    if (adcStart) begin
      if (!adcPowerUp) powerViol <= powerViol + 1;
      if (startCount == baseStart) firstStartCyc <= cyc;
      pendVal <= adcTempSel ? tempVal(startCount - baseStart)
                            : chanVal(int'(muxSel), startCount - baseStart);
      startCount <= startCount + 1;
      pendCnt <= 2;
    end else if (pendCnt == 1) begin
      adcDone <= 1'b1;
      adcData <= pendVal;
      pendCnt <= 0;
    end else if (pendCnt > 1) begin
      pendCnt <= pendCnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected entries
  int expTag [0:63];
  int expVal [0:63];
  int nExp = 0;
  int expStarts = 0;

  function automatic int shiftOf(input int code);
    case (code)
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic buildExp(input logic [15:0] mask, input bit temp, input int code);
    int idx = 0;
    int n = 1 << shiftOf(code);
    nExp = 0;
    if (temp) begin
      expTag[nExp] = 15; expVal[nExp] = int'(tempVal(idx)); idx++; nExp++;
    end
    for (int ch = 0; ch < 16; ch++) begin
      if (mask[ch]) begin
        int sum = 0;
        for (int k = 0; k < n; k++) begin
          sum += int'(chanVal(ch, idx)); idx++;
        end
        expTag[nExp] = ch; expVal[nExp] = sum >> shiftOf(code); nExp++;
      end
    end
    expStarts = idx;
  endtask

  task automatic issueCmd(input logic [15:0] mask, input bit temp, input int code);
    @(negedge clk);
    csN = 1'b0; cmdValid = 1'b1; cmdChanMask = mask; cmdTempReq = temp;
    cmdAvgSel = 3'(code); baseStart = startCount; cmdCycle = cyc;
    @(negedge clk);
    cmdValid = 1'b0; csN = 1'b1;
  endtask

  task automatic waitEoc();
    int t = 0;
    while (eocN && t < 20000) begin @(negedge clk); t++; end
    check(!eocN, "R6 eoc low at end", int'(eocN), 0);
  endtask

  task automatic releaseEoc();
    repeat (8) @(negedge clk);
    check(!eocN, "R6 eoc held while csN high", int'(eocN), 0);
    check(!adcPowerUp, "R7 power down after scan", int'(adcPowerUp), 0);
    csN = 1'b0;
    @(negedge clk);
    csN = 1'b1;
    check(eocN, "R6 eoc cleared by csN", int'(eocN), 1);
  endtask

  task automatic drainRange(input int from, input int cnt, input string req);
    for (int i = from; i < from + cnt; i++) begin
      check(!fifoEmpty, req, int'(fifoEmpty), 0);
      check(int'(fifoRdData[15:12]) == expTag[i], {req, " tag"}, int'(fifoRdData[15:12]), expTag[i]);
      check(int'(fifoRdData[11:0]) == expVal[i], {req, " value"}, int'(fifoRdData[11:0]), expVal[i]);
      fifoRdEn = 1'b1;
      @(negedge clk);
      fifoRdEn = 1'b0;
    end
  endtask

  task automatic runScan(input logic [15:0] mask, input bit temp, input int code, input string req);
    buildExp(mask, temp, code);
    issueCmd(mask, temp, code);
    waitEoc();
    check(startCount - baseStart == expStarts, {req, " start count (R5)"}, startCount - baseStart, expStarts);
    check(firstStartCyc - cmdCycle >= WAKE, "R2 wake delay", firstStartCyc - cmdCycle, WAKE);
    releaseEoc();
    drainRange(0, nExp, req);
    check(fifoEmpty, {req, " empty after drain (R11)"}, int'(fifoEmpty), 1);
  endtask

  task automatic testReset();
    check(eocN, "R1 eocN reset", int'(eocN), 1);
    check(!adcPowerUp, "R1 power reset", int'(adcPowerUp), 0);
    check(fifoEmpty, "R1 fifo empty reset", int'(fifoEmpty), 1);
    check(!fifoOverflow, "R1 overflow reset", int'(fifoOverflow), 0);
  endtask

  task automatic testEmptyRead();
    fifoRdEn = 1'b1;
    @(negedge clk);
    fifoRdEn = 1'b0;
    check(fifoEmpty, "R11 read while empty", int'(fifoEmpty), 1);
  endtask

  task automatic testZeroMask();
    issueCmd(16'h0000, 1'b0, 0);
    waitEoc();
    check(startCount == baseStart, "R8 no conversions", startCount - baseStart, 0);
    check(fifoEmpty, "R8 no fifo entry", int'(fifoEmpty), 1);
    releaseEoc();
  endtask

  task automatic testBusyCmd();
    buildExp(16'h0003, 1'b0, 4);
    issueCmd(16'h0003, 1'b0, 4);
    repeat (20) @(negedge clk);
    cmdValid = 1'b1; cmdChanMask = 16'hFFFF; cmdTempReq = 1'b1; cmdAvgSel = 3'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    waitEoc();
    check(startCount - baseStart == expStarts, "R10 scan not widened", startCount - baseStart, expStarts);
    releaseEoc();
    drainRange(0, nExp, "R10 entries");
    check(fifoEmpty, "R10 no extra entries", int'(fifoEmpty), 1);
  endtask

  task automatic testOverflow();
    buildExp(16'hFFFF, 1'b1, 0);
    issueCmd(16'hFFFF, 1'b1, 0);
    waitEoc();
    releaseEoc();
    check(!fifoOverflow, "R9 no overflow below depth", int'(fifoOverflow), 0);
    issueCmd(16'hFFFF, 1'b1, 0);
    waitEoc();
    releaseEoc();
    check(fifoOverflow, "R9 overflow set", int'(fifoOverflow), 1);
    drainRange(0, nExp, "R9 first scan kept");
    drainRange(0, DEPTH - nExp, "R9 second scan head kept");
    check(fifoEmpty, "R9 only depth entries", int'(fifoEmpty), 1);
    check(fifoOverflow, "R9 overflow sticky", int'(fifoOverflow), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEmptyRead();
    runScan(16'h0025, 1'b1, 0, "R3 R4 temp first ascending");
    runScan(16'h8001, 1'b0, 2, "R5 avg 8");
    runScan(16'h0010, 1'b0, 4, "R5 avg 32");
    runScan(16'h0006, 1'b1, 1, "R5 avg 4 with temp");
    runScan(16'h0009, 1'b0, 3, "R5 avg 16");
    runScan(16'h0300, 1'b0, 7, "R5 code 7 acts as 1");
    testZeroMask();
    testBusyCmd();
    testOverflow();
    check(powerViol == 0, "R2 power high at every start", powerViol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule